// File: doc/BRIEF.md
# Change-of-State Input Monitor

This block watches a parallel input word, 24 bits by default, and tells a single client when any bit of it changes. The word is sampled on a poll period programmed in milliseconds. A millisecond tick comes from the system clock through a prescaler. An edge-interrupt request line forces a sample at once, without waiting for the poll timer. A sample that differs from the one before it produces a report that carries the whole current input word.

A start command turns reporting on and records the identity of the client that issued it. It also sends one report of the current word, so the client learns the initial state. A stop command turns reporting off and withdraws any report that has not been taken. Reports leave on a valid/ready interface. A change found while a report is still waiting replaces the waiting value instead of queueing a second report. The stored previous sample keeps following the input while reporting is off, so a restart does not report old changes.

Top module: `cos_monitor`

## Requirements
- R1: After reset, rpt_valid is 0, rpt_client is 0 and reporting is off.
- R2: A millisecond tick occurs once every PRESCALE clock cycles. A poll sample is taken on the tick that completes poll_ms milliseconds since the previous poll, counted from reset.
- R3: A poll_ms value of 0 selects a poll period of DEFAULT_MS (100) milliseconds.
- R4: An irq_req pulse samples din in that cycle. When the sample differs and reporting is on, rpt_valid is 1 on the next cycle.
- R5: A poll or irq sample that differs from the previous sample in any bit, taken while reporting is on, loads rpt_data with the full sampled din and raises rpt_valid on the next cycle.
- R6: A sample that equals the previous sample starts no report.
- R7: mon_stop clears rpt_valid on the next cycle and turns reporting off. mon_stop takes priority over mon_start in the same cycle.
- R8: mon_start (without mon_stop) turns reporting on. It latches client_in into rpt_client, samples din and reports that value on the next cycle, whether or not din has changed.
- R9: A reportable change that occurs while rpt_valid is 1 and rpt_ready is 0 overwrites rpt_data with the new value. It does not create a second report.
- R10: The previous sample updates on every sample even while reporting is off, so changes made while stopped are not reported after a restart.
- R11: Once raised, rpt_valid stays 1 until a cycle with rpt_ready at 1, unless mon_stop is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DATA_W | Monitored input word |
| poll_ms | input | PERIOD_W | Poll period in milliseconds, 0 selects DEFAULT_MS |
| irq_req | input | 1 | Edge-interrupt request that forces an immediate sample |
| mon_start | input | 1 | Start-monitor command pulse |
| mon_stop | input | 1 | Stop-monitor command pulse |
| client_in | input | ID_W | Identity of the client issuing mon_start |
| rpt_valid | output | 1 | A report is waiting |
| rpt_ready | input | 1 | Client accepts the report |
| rpt_data | output | DATA_W | Input value carried by the report |
| rpt_client | output | ID_W | Client that most recently started monitoring |

## Verification
The hardest situation to reach is a change that arrives while a report is already waiting. The same case matters while a stop arrives in the same cycle as a start, or while a poll and an interrupt line up. The bench holds rpt_ready low and issues interrupt pulses with new input values. It then releases ready, so a single coalesced report should appear. It also runs with a short prescaler and poll period so that poll strobes fall on cycles where commands are also pending. A behavioural model, compared every cycle, decides what each of these collisions should give.

// File: rtl/cosm_pkg.sv
package cosm_pkg;
   localparam int unsigned COSM_DEFAULT_MS = 100;

   function automatic int unsigned cosm_cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cosm_ms_tick.sv
module cosm_ms_tick #(
   parameter int unsigned PRESCALE = 125000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   import cosm_pkg::*;
   localparam int unsigned CW = cosm_cnt_w(PRESCALE);

   generate
      if (PRESCALE < 1) begin : g_bad
         $error("cosm_ms_tick: PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)    cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(PRESCALE - 1));

         p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/cosm_poll_timer.sv
module cosm_poll_timer #(
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned DEFAULT_MS = 100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [PERIOD_W-1:0] poll_ms,
   output logic                poll_fire
);
   logic [PERIOD_W-1:0] eff_ms;
   logic [PERIOD_W-1:0] ms_cnt;

   generate
      if (DEFAULT_MS < 1 || DEFAULT_MS >= (64'd1 << PERIOD_W)) begin : g_bad
         $error("cosm_poll_timer: DEFAULT_MS must be nonzero and fit PERIOD_W");
      end
   endgenerate

   assign eff_ms    = (poll_ms == '0) ? PERIOD_W'(DEFAULT_MS) : poll_ms;
   assign poll_fire = tick && (ms_cnt >= eff_ms - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)         ms_cnt <= '0;
      else if (poll_fire) ms_cnt <= '0;
      else if (tick)      ms_cnt <= ms_cnt + 1'b1;
   end

   p_fire_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      poll_fire |-> tick);
   p_count_restarts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      poll_fire |=> (ms_cnt == '0));
endmodule

// File: rtl/cosm_report.sv
module cosm_report #(
   parameter int unsigned DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              cancel,
   input  logic [DATA_W-1:0] load_data,
   input  logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (cancel) begin
         valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end

   p_hold_until_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !cancel) |=> valid);
   p_cancel_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !valid);
endmodule

// File: rtl/cos_monitor.sv
module cos_monitor #(
   parameter int unsigned DATA_W     = 24,
   parameter int unsigned PERIOD_W   = 16,
   parameter int unsigned ID_W       = 4,
   parameter int unsigned PRESCALE   = 125000,
   parameter int unsigned DEFAULT_MS = cosm_pkg::COSM_DEFAULT_MS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   din,
   input  logic [PERIOD_W-1:0] poll_ms,
   input  logic                irq_req,
   input  logic                mon_start,
   input  logic                mon_stop,
   input  logic [ID_W-1:0]     client_in,
   output logic                rpt_valid,
   input  logic                rpt_ready,
   output logic [DATA_W-1:0]   rpt_data,
   output logic [ID_W-1:0]     rpt_client
);
   generate
      if (DATA_W < 1 || ID_W < 1 || PERIOD_W < 1) begin : g_bad
         $error("cos_monitor: widths must be at least 1");
      end
   endgenerate

   logic              ms_tick;
   logic              poll_fire;
   logic              start_ok;
   logic              sample;
   logic              changed;
   logic              load;
   logic              mon_on;
   logic [DATA_W-1:0] prev_q;
   logic [ID_W-1:0]   owner_q;

   cosm_ms_tick #(.PRESCALE(PRESCALE)) u_tick (
      .clk (clk), .rst_n (rst_n), .tick (ms_tick)
   );

   cosm_poll_timer #(.PERIOD_W(PERIOD_W), .DEFAULT_MS(DEFAULT_MS)) u_poll (
      .clk (clk), .rst_n (rst_n), .tick (ms_tick),
      .poll_ms (poll_ms), .poll_fire (poll_fire)
   );

   assign start_ok = mon_start && !mon_stop;
   assign sample   = poll_fire || irq_req || start_ok;
   assign changed  = (din != prev_q);
   assign load     = start_ok || (mon_on && !mon_stop && (poll_fire || irq_req) && changed);

   always_ff @(posedge clk) begin
      if (!rst_n)      prev_q <= '0;
      else if (sample) prev_q <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_on  <= 1'b0;
         owner_q <= '0;
      end else if (mon_stop) begin
         mon_on  <= 1'b0;
      end else if (mon_start) begin
         mon_on  <= 1'b1;
         owner_q <= client_in;
      end
   end

   cosm_report #(.DATA_W(DATA_W)) u_rpt (
      .clk (clk), .rst_n (rst_n), .load (load), .cancel (mon_stop),
      .load_data (din), .ready (rpt_ready), .valid (rpt_valid), .data (rpt_data)
   );

   assign rpt_client = owner_q;

   p_start_reports_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (rpt_valid && rpt_data == $past(din)));
   p_rise_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rpt_valid) |-> $past(mon_start || irq_req || poll_fire));
   p_silent_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_on && !mon_start) |=> !rpt_valid || $stable(rpt_data));
   p_irq_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_on && !mon_stop && irq_req && changed) |=> (rpt_valid && rpt_data == $past(din)));
endmodule

// File: tb/cos_monitor_test.sv
module cos_monitor_test;
   localparam int DW = 24, PW = 16, IW = 4, PS = 4, DEF = 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [PW-1:0] poll_ms = '0;
   logic          irq_req = 1'b0, mon_start = 1'b0, mon_stop = 1'b0, rpt_ready = 1'b0;
   logic [IW-1:0] client_in = '0;
   logic          rpt_valid;
   logic [DW-1:0] rpt_data;
   logic [IW-1:0] rpt_client;

   always #4 clk = ~clk;

   cos_monitor #(.DATA_W(DW), .PERIOD_W(PW), .ID_W(IW), .PRESCALE(PS), .DEFAULT_MS(DEF)) uut (
      .clk (clk), .rst_n (rst_n), .din (din), .poll_ms (poll_ms), .irq_req (irq_req),
      .mon_start (mon_start), .mon_stop (mon_stop), .client_in (client_in),
      .rpt_valid (rpt_valid), .rpt_ready (rpt_ready), .rpt_data (rpt_data),
      .rpt_client (rpt_client)
   );

   int errors = 0, checks = 0, cycles = 0, handshakes = 0;
   string phase = "R1";

   // behavioural reference state
   int      m_pc = 0, m_mc = 0;
   bit      m_valid = 0, m_on = 0;
   int      m_prev = 0, m_data = 0, m_owner = 0;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_mc = 0; m_valid = 0; m_on = 0; m_prev = 0; m_data = 0; m_owner = 0;
      end else begin
         bit tick, fire, st, rep;
         int eff;
         if (m_valid && rpt_ready) handshakes++;
         tick = (m_pc == PS - 1);
         m_pc = tick ? 0 : m_pc + 1;
         eff  = (poll_ms == 0) ? DEF : int'(poll_ms);
         fire = tick && (m_mc >= eff - 1);
         m_mc = fire ? 0 : (tick ? m_mc + 1 : m_mc);
         st   = mon_start && !mon_stop;
         rep  = st || (m_on && !mon_stop && (fire || irq_req) && (int'(din) != m_prev));
         if (mon_stop) m_valid = 0;
         else if (rep) begin m_valid = 1; m_data = int'(din); end
         else if (m_valid && rpt_ready) m_valid = 0;
         if (fire || irq_req || st) m_prev = int'(din);
         if (mon_stop) m_on = 0;
         else if (mon_start) begin m_on = 1; m_owner = int'(client_in); end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check(phase, "rpt_valid", rpt_valid, m_valid);
         if (m_valid) check(phase, "rpt_data", rpt_data, m_data);
         check(phase, "rpt_client", rpt_client, m_owner);
      end
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
         summary();
      end
   end

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_irq(input logic [DW-1:0] v);
      din = v; irq_req = 1'b1;
      @(negedge clk); irq_req = 1'b0;
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset rpt_valid", rpt_valid, 0);
      check("R1", "reset rpt_client", rpt_client, 0);

      phase = "R6"; poll_ms = 3; din = 24'h00A5A5; rpt_ready = 1'b1;
      wait_n(40);                    // off: polls but no reports
      check("R6", "no report while off", rpt_valid, 0);

      phase = "R8"; client_in = 4'd5; mon_start = 1'b1;
      @(negedge clk); mon_start = 1'b0; client_in = 4'd0;
      check("R8", "start report valid", rpt_valid, 1);
      check("R8", "start report data", rpt_data, 24'h00A5A5);
      check("R8", "owner latched", rpt_client, 5);

      phase = "R2"; wait_n(5); din = 24'h123456; wait_n(30);
      din = 24'h123457; wait_n(30);
      phase = "R6"; wait_n(40);

      phase = "R4"; pulse_irq(24'hFFFFFF);
      check("R4", "irq report valid", rpt_valid, 1);
      check("R4", "irq report data", rpt_data, 24'hFFFFFF);
      pulse_irq(24'hFFFFFF);  // same value
      check("R6", "repeat irq no report", rpt_valid, 0);

      phase = "R9"; rpt_ready = 1'b0; handshakes = 0;
      pulse_irq(24'h000001); pulse_irq(24'h000002); pulse_irq(24'h000004);
      check("R9", "coalesced data", rpt_data, 24'h000004);
      phase = "R11"; wait_n(6);
      check("R11", "held valid", rpt_valid, 1);
      rpt_ready = 1'b1; @(negedge clk); rpt_ready = 1'b0;
      check("R9", "single handshake", handshakes, 1);
      check("R9", "drained", rpt_valid, 0);
      rpt_ready = 1'b1;

      phase = "R7"; rpt_ready = 1'b0; pulse_irq(24'h0F0F0F);
      mon_stop = 1'b1; @(negedge clk); mon_stop = 1'b0;
      check("R7", "stop cancels", rpt_valid, 0);
      rpt_ready = 1'b1;
      pulse_irq(24'h333333);
      check("R7", "silent after stop", rpt_valid, 0);
      mon_start = 1'b1; mon_stop = 1'b1; client_in = 4'd9;
      @(negedge clk); mon_start = 1'b0; mon_stop = 1'b0;
      check("R7", "stop beats start", rpt_valid, 0);
      check("R7", "owner unchanged", rpt_client, 5);

      phase = "R10"; din = 24'h777000; wait_n(30);
      client_in = 4'd3; mon_start = 1'b1; @(negedge clk); mon_start = 1'b0;
      check("R10", "restart report", rpt_data, 24'h777000);
      check("R8", "new owner", rpt_client, 3);
      wait_n(40);
      check("R10", "no stale report", rpt_valid, 0);

      phase = "R3"; poll_ms = 0; wait_n(450);
      din = 24'hABCDEF;
      wait_n(850);
      din = 24'h000000;
      wait_n(850);

      phase = "R5"; poll_ms = 1;
      for (int k = 0; k < 8; k++) begin din = DW'(k * 24'h111111); wait_n(7); end
      wait_n(10);
      summary();
   end
endmodule